// File: doc/BRIEF.md
# Flash Command Sequencer

This block connects a 32-bit memory-mapped bus slave port to a 16-bit parallel NOR flash that speaks the common CFI command set. The upper bus address bits choose an operation window. A single bus access to a window becomes the full multi-cycle flash command sequence for that operation. The bus master never sends raw flash commands itself.

Program and erase sequences end with a status-polling loop that stops only when the device reports ready. The last status byte read is kept in a register that software can read. While a sequence runs, the bus acknowledge is held off and a busy output stays high, so the master simply stalls.

Each flash cycle lasts a fixed number of clocks set by a parameter. During a cycle the address, the data and the write flag are held steady.

Top module: `flash_seq`

## Requirements
- R1: Window decode uses bus address bits [27:26]. 00 is the array window: a write programs, a read reads. 01 is unlock (write only). 10 is erase (write only). For 11, bit 25 = 0 selects the register bank, with bit 2 choosing between control (+0) and status (+4). Bit 25 = 1 selects identifier reads when bit 16 = 0 and query reads when bit 16 = 1. Any access that none of these cases names completes with no flash cycle and reads zero.
- R2: A write to the array window issues, in order: 0x0050 at flash address 0, then 0x0040 at the target, then the low 16 data bits at the target. The target is bus address bits [23:0].
- R3: After a program or an erase, the block repeats "write 0x0070 at address 0, then read" until read bit 7 is 1. It acknowledges only after that read. The status register (+4) then holds the low 8 bits of that last read, and its upper 24 bits read as zero.
- R4: A write to the unlock window issues 0x0060 and then 0x00D0, both at the target, and no status poll.
- R5: A write to the erase window issues 0x0050 at 0, then 0x0060, 0x00D0, 0x0020 and 0x00D0 at the target, then the R3 poll loop.
- R6: An identifier read issues 0x0090 at address 0. A query read issues 0x0098 at address 0. Each then reads flash address {bus bits[14:0],0} and returns that word in rdata[15:0], with the upper bits zero.
- R7: An array read issues 0x00FF at address 0, then reads the target. It returns the word in rdata[15:0].
- R8: A control write with bit 1 set issues 0x0050 and zeroes the status register. A control write with bit 2 set issues 0x00FF. With both bits set, 0x0050 comes first and then 0x00FF. With neither bit set, no flash cycle occurs.
- R9: busy is 1 from the clock edge that accepts a request through the acknowledge cycle. ack is a one-cycle pulse.
- R10: Every flash cycle holds fl_cs high for exactly WAIT_CYC clocks, with fl_addr, fl_dout and fl_we unchanged for that whole time.
- R11: After reset, ack, busy and fl_cs are 0, and the status register reads 0.
- R12: A write to the status offset (+4) leaves the status register unchanged. A control read returns busy in bit 0 (0 when the read is acknowledged) and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 28 | Bus byte address including window bits |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, valid with ack |
| ack | output | 1 | One-cycle acknowledge |
| busy | output | 1 | Sequence in progress |
| fl_addr | output | 24 | Flash byte address |
| fl_dout | output | 16 | Data driven to flash |
| fl_din | input | 16 | Data from flash |
| fl_cs | output | 1 | Flash cycle active |
| fl_we | output | 1 | Flash cycle is a write |

## Verification
The bench uses a behavioural flash that reports not-ready for two status reads after each program or erase. It logs every command, so the exact order of each sequence is checked. A design that left the poll loop after the first read would ack early and capture 0x00 instead of 0x80. A design that dropped the unlock step from the erase, or put clear-status after unlock, would show a wrong log entry. An injected error bit in the erase status checks that all eight low bits are captured. The bench checks the doubled address for identifier and query reads, the write to +4 that must be ignored, and a control write with no bits set, which must produce no flash cycle at all. It also measures the width of every fl_cs pulse, which catches an off-by-one in the wait-state counter.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_ARR_RD, OP_PROG, OP_UNLK, OP_ERASE,
    OP_CLR, OP_RST, OP_CLRRST, OP_ID, OP_QRY
  } op_e;

  typedef enum logic [2:0] {
    K_END, K_WCMD, K_WDATA, K_RD, K_PCMD, K_PRD
  } kind_e;

  typedef enum logic [1:0] {RS_ZERO, RS_CTRL, RS_STAT} rsrc_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] cmd;
    logic       tgt;   // 1: target address, 0: flash address 0
  } step_t;

  function automatic step_t mk(kind_e k, logic [7:0] c, logic t);
    step_t s;
    s.kind = k;
    s.cmd  = c;
    s.tgt  = t;
    return s;
  endfunction

  // Command sequence table, indexed by operation and step number.
  function automatic step_t get_step(op_e op, logic [2:0] idx);
    step_t s;
    s = mk(K_END, 8'h00, 1'b0);
    case (op)
      OP_ARR_RD: case (idx)
        3'd0: s = mk(K_WCMD, 8'hFF, 1'b0);
        3'd1: s = mk(K_RD,   8'h00, 1'b1);
        default: ;
      endcase
      OP_PROG: case (idx)
        3'd0: s = mk(K_WCMD,  8'h50, 1'b0);
        3'd1: s = mk(K_WCMD,  8'h40, 1'b1);
        3'd2: s = mk(K_WDATA, 8'h00, 1'b1);
        3'd3: s = mk(K_PCMD,  8'h70, 1'b0);
        3'd4: s = mk(K_PRD,   8'h00, 1'b0);
        default: ;
      endcase
      OP_UNLK: case (idx)
        3'd0: s = mk(K_WCMD, 8'h60, 1'b1);
        3'd1: s = mk(K_WCMD, 8'hD0, 1'b1);
        default: ;
      endcase
      OP_ERASE: case (idx)
        3'd0: s = mk(K_WCMD, 8'h50, 1'b0);
        3'd1: s = mk(K_WCMD, 8'h60, 1'b1);
        3'd2: s = mk(K_WCMD, 8'hD0, 1'b1);
        3'd3: s = mk(K_WCMD, 8'h20, 1'b1);
        3'd4: s = mk(K_WCMD, 8'hD0, 1'b1);
        3'd5: s = mk(K_PCMD, 8'h70, 1'b0);
        3'd6: s = mk(K_PRD,  8'h00, 1'b0);
        default: ;
      endcase
      OP_CLR:    if (idx == 3'd0) s = mk(K_WCMD, 8'h50, 1'b0);
      OP_RST:    if (idx == 3'd0) s = mk(K_WCMD, 8'hFF, 1'b0);
      OP_CLRRST: case (idx)
        3'd0: s = mk(K_WCMD, 8'h50, 1'b0);
        3'd1: s = mk(K_WCMD, 8'hFF, 1'b0);
        default: ;
      endcase
      OP_ID: case (idx)
        3'd0: s = mk(K_WCMD, 8'h90, 1'b0);
        3'd1: s = mk(K_RD,   8'h00, 1'b1);
        default: ;
      endcase
      OP_QRY: case (idx)
        3'd0: s = mk(K_WCMD, 8'h98, 1'b0);
        3'd1: s = mk(K_RD,   8'h00, 1'b1);
        default: ;
      endcase
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fs_decode.sv
module fs_decode
  import fs_pkg::*;
#(
  parameter int AW = 28,
  parameter int FA = 24
) (
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [31:0]   wdata,
  output op_e           op,
  output rsrc_e         rsrc,
  output logic [FA-1:0] tgt
);
  localparam int IDX_W = 15;

  logic idq;

  always_comb begin
    op   = OP_NONE;
    rsrc = RS_ZERO;
    idq  = 1'b0;
    case (addr[27:26])
      2'b00: op = we ? OP_PROG : OP_ARR_RD;
      2'b01: op = we ? OP_UNLK : OP_NONE;
      2'b10: op = we ? OP_ERASE : OP_NONE;
      default: begin
        if (!addr[25]) begin
          if (!we)
            rsrc = addr[2] ? RS_STAT : RS_CTRL;
          else if (!addr[2])
            case (wdata[2:1])
              2'b01:   op = OP_CLR;
              2'b10:   op = OP_RST;
              2'b11:   op = OP_CLRRST;
              default: op = OP_NONE;
            endcase
        end else if (!we) begin
          op  = addr[16] ? OP_QRY : OP_ID;
          idq = 1'b1;
        end
      end
    endcase
  end

  assign tgt = idq ? FA'({addr[IDX_W-1:0], 1'b0}) : addr[FA-1:0];

endmodule

// File: rtl/fs_cycle.sv
module fs_cycle #(
  parameter int FA       = 24,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_wr,
  input  logic [FA-1:0] addr_i,
  input  logic [15:0]   data_i,
  output logic          done,
  output logic [15:0]   rd_o,
  output logic [FA-1:0] fl_addr,
  output logic [15:0]   fl_dout,
  input  logic [15:0]   fl_din,
  output logic          fl_cs,
  output logic          fl_we
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_cs   <= 1'b0;
      fl_we   <= 1'b0;
      fl_addr <= '0;
      fl_dout <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      rd_o    <= '0;
    end else begin
      done <= 1'b0;
      if (!fl_cs) begin
        if (start) begin
          fl_cs   <= 1'b1;
          fl_we   <= is_wr;
          fl_addr <= addr_i;
          fl_dout <= data_i;
          cnt     <= CNT_INIT;
        end
      end else if (cnt == '0) begin
        fl_cs <= 1'b0;
        fl_we <= 1'b0;
        done  <= 1'b1;
        rd_o  <= fl_din;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R10: flash signals stay put during a cycle
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (fl_cs && $past(fl_cs)) |-> ($stable(fl_addr) && $stable(fl_dout) && $stable(fl_we)));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import fs_pkg::*;
#(
  parameter int AW       = 28,
  parameter int FA       = 24,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          ack,
  output logic          busy,
  output logic [FA-1:0] fl_addr,
  output logic [15:0]   fl_dout,
  input  logic [15:0]   fl_din,
  output logic          fl_cs,
  output logic          fl_we
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_ACK} st_e;

  st_e           state;
  op_e           op_q;
  logic [FA-1:0] tgt_q;
  logic [15:0]   wd_q;
  logic [2:0]    idx_q;
  logic [7:0]    status_q;

  op_e           dec_op;
  rsrc_e         dec_rsrc;
  logic [FA-1:0] dec_tgt;
  step_t         cur, nxt, first;
  logic          start, done, cyc_wr;
  logic [15:0]   rd;

  fs_decode #(.AW(AW), .FA(FA)) u_dec (
    .addr(addr), .we(we), .wdata(wdata),
    .op(dec_op), .rsrc(dec_rsrc), .tgt(dec_tgt)
  );

  assign cur    = get_step(op_q, idx_q);
  assign nxt    = get_step(op_q, idx_q + 3'd1);
  assign first  = get_step(dec_op, 3'd0);
  assign start  = (state == S_ISSUE);
  assign cyc_wr = (cur.kind == K_WCMD) || (cur.kind == K_WDATA) || (cur.kind == K_PCMD);

  fs_cycle #(.FA(FA), .WAIT_CYC(WAIT_CYC)) u_cyc (
    .clk(clk), .rst(rst), .start(start), .is_wr(cyc_wr),
    .addr_i(cur.tgt ? tgt_q : '0),
    .data_i((cur.kind == K_WDATA) ? wd_q : {8'h00, cur.cmd}),
    .done(done), .rd_o(rd),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_cs(fl_cs), .fl_we(fl_we)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_NONE;
      tgt_q    <= '0;
      wd_q     <= '0;
      idx_q    <= '0;
      status_q <= '0;
      rdata    <= '0;
      ack      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req) begin
          op_q  <= dec_op;
          tgt_q <= dec_tgt;
          wd_q  <= wdata[15:0];
          idx_q <= '0;
          case (dec_rsrc)
            RS_CTRL: rdata <= {31'd0, busy};
            RS_STAT: rdata <= {24'd0, status_q};
            default: rdata <= '0;
          endcase
          if (first.kind == K_END) begin
            ack   <= 1'b1;
            state <= S_ACK;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (cur.kind == K_WCMD && cur.cmd == 8'h50) status_q <= '0;
          state <= S_WAIT;
        end
        S_WAIT: if (done) begin
          if (cur.kind == K_RD) rdata <= {16'd0, rd};
          if (cur.kind == K_PRD) status_q <= rd[7:0];
          if (cur.kind == K_PRD && !rd[7]) begin
            idx_q <= idx_q - 3'd1;
            state <= S_ISSUE;
          end else if (nxt.kind == K_END) begin
            ack   <= 1'b1;
            state <= S_ACK;
          end else begin
            idx_q <= idx_q + 3'd1;
            state <= S_ISSUE;
          end
        end
        default: begin
          ack   <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  // R9: acknowledge lasts one cycle
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  // R9: any flash activity happens inside a busy window
  assert_busy_cover_R9: assert property (@(posedge clk) disable iff (rst)
    fl_cs |-> busy);
  // R3: a not-ready status read never leads straight to an acknowledge
  assert_poll_no_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && done && cur.kind == K_PRD && !rd[7]) |=> !ack);
  // R11: flash idle while the sequencer is idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !fl_cs);

endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  localparam int WAIT_CYC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [27:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack, busy;
  logic [23:0] fl_addr;
  logic [15:0] fl_dout, fl_din;
  logic        fl_cs, fl_we;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_seq #(.WAIT_CYC(WAIT_CYC)) u0 (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .busy(busy),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_cs(fl_cs), .fl_we(fl_we)
  );

  // ---------------- behavioural flash ----------------
  typedef enum logic [1:0] {M_ARR, M_STAT, M_ID, M_QRY} mode_e;
  mode_e       mode = M_ARR;
  logic [15:0] mem [256];
  logic [7:0]  err_bits = 8'h00;
  int          bcnt = 0;
  logic        pend_prog = 1'b0, pend_erase = 1'b0;
  logic        cs_p = 1'b0, we_p = 1'b0;
  logic [15:0] log_d [64];
  logic [23:0] log_a [64];
  int          log_n = 0;
  int          cs_len = 0;
  int          bad_len = 0;

  always_comb begin
    case (mode)
      M_ARR:   fl_din = mem[fl_addr[8:1]];
      M_STAT:  fl_din = {8'h00, (bcnt == 0) ? (8'h80 | err_bits) : 8'h00};
      M_ID:    fl_din = 16'h0089 ^ fl_addr[15:0];
      default: fl_din = 16'h0051 ^ fl_addr[15:0];
    endcase
  end

  always @(posedge clk) begin
    cs_p <= fl_cs;
    we_p <= fl_we;
    if (fl_cs) cs_len <= cs_len + 1;
    if (!fl_cs && cs_p) begin
      cs_len <= 0;
      if (cs_len != WAIT_CYC) bad_len <= bad_len + 1;
      if (!we_p && mode == M_STAT && bcnt > 0) bcnt <= bcnt - 1;
    end
    if (fl_cs && !cs_p && fl_we) begin
      log_d[log_n % 64] <= fl_dout;
      log_a[log_n % 64] <= fl_addr;
      log_n <= log_n + 1;
      if (pend_prog) begin
        mem[fl_addr[8:1]] <= fl_dout;
        pend_prog <= 1'b0;
        bcnt <= 2;
        mode <= M_STAT;
      end else case (fl_dout[7:0])
        8'hFF: mode <= M_ARR;
        8'h70: mode <= M_STAT;
        8'h90: mode <= M_ID;
        8'h98: mode <= M_QRY;
        8'h40: pend_prog <= 1'b1;
        8'h20: pend_erase <= 1'b1;
        8'hD0: if (pend_erase) begin
          pend_erase <= 1'b0;
          bcnt <= 2;
          mode <= M_STAT;
        end
        default: ;
      endcase
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  logic all_busy;
  int   xfer_cyc;

  task automatic xfer(input logic w, input logic [27:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    all_busy = 1'b1;
    xfer_cyc = 0;
    do begin
      @(posedge clk); #1;
      xfer_cyc++;
      if (!busy) all_busy = 1'b0;
    end while (!ack && xfer_cyc < 2000);
    rd = rdata;
    if (!ack) check("R9 ack timeout", 32'd0, 32'd1);
    @(negedge clk);
    req = 1'b0;
    @(posedge clk); #1;
    check("R9 ack single pulse", {31'd0, ack}, 32'd0);
  endtask

  task automatic chk_log(string r, int base, int idx, logic [15:0] d, logic [23:0] a);
    check({r, " cmd"},  {16'd0, log_d[(base + idx) % 64]}, {16'd0, d});
    check({r, " addr"}, {8'd0, log_a[(base + idx) % 64]}, {8'd0, a});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] r;
    check("R11 ack", {31'd0, ack}, 32'd0);
    check("R11 busy", {31'd0, busy}, 32'd0);
    check("R11 fl_cs", {31'd0, fl_cs}, 32'd0);
    xfer(1'b0, 28'hC000004, 32'd0, r);
    check("R11 status after reset", r, 32'd0);
  endtask

  task automatic t_program;
    int b; logic [31:0] r;
    b = log_n;
    xfer(1'b1, 28'h0000010, 32'h1234BEEF, r);
    check("R9 busy throughout", {31'd0, all_busy}, 32'd1);
    check("R2 log length", log_n - b, 6);
    chk_log("R2 step0", b, 0, 16'h0050, 24'h0);
    chk_log("R2 step1", b, 1, 16'h0040, 24'h10);
    chk_log("R2 step2", b, 2, 16'hBEEF, 24'h10);
    chk_log("R3 poll1", b, 3, 16'h0070, 24'h0);
    chk_log("R3 poll3", b, 5, 16'h0070, 24'h0);
    xfer(1'b0, 28'hC000004, 32'd0, r);
    check("R3 status after program", r, 32'h80);
  endtask

  task automatic t_array_read;
    int b; logic [31:0] r;
    b = log_n;
    xfer(1'b0, 28'h0000010, 32'd0, r);
    check("R7 data", r, 32'h0000BEEF);
    check("R7 log length", log_n - b, 1);
    chk_log("R7 mode cmd", b, 0, 16'h00FF, 24'h0);
  endtask

  task automatic t_unlock;
    int b; logic [31:0] r;
    b = log_n;
    xfer(1'b1, 28'h4000020, 32'd0, r);
    check("R4 log length", log_n - b, 2);
    chk_log("R4 step0", b, 0, 16'h0060, 24'h20);
    chk_log("R4 step1", b, 1, 16'h00D0, 24'h20);
  endtask

  task automatic t_erase;
    int b; logic [31:0] r;
    b = log_n;
    err_bits = 8'h20;
    xfer(1'b1, 28'h8000040, 32'd0, r);
    check("R5 log length", log_n - b, 8);
    chk_log("R5 step0", b, 0, 16'h0050, 24'h0);
    chk_log("R5 step1", b, 1, 16'h0060, 24'h40);
    chk_log("R5 step2", b, 2, 16'h00D0, 24'h40);
    chk_log("R5 step3", b, 3, 16'h0020, 24'h40);
    chk_log("R5 step4", b, 4, 16'h00D0, 24'h40);
    chk_log("R5 poll", b, 5, 16'h0070, 24'h0);
    xfer(1'b0, 28'hC000004, 32'd0, r);
    check("R3 status with error bit", r, 32'hA0);
    err_bits = 8'h00;
  endtask

  task automatic t_status_ignore;
    int b; logic [31:0] r;
    b = log_n;
    xfer(1'b1, 28'hC000004, 32'hFFFFFFFF, r);
    check("R12 no flash cycle", log_n - b, 0);
    xfer(1'b0, 28'hC000004, 32'd0, r);
    check("R12 status unchanged", r, 32'hA0);
    xfer(1'b0, 28'hC000000, 32'd0, r);
    check("R12 control read", r, 32'd0);
  endtask

  task automatic t_ident_query;
    int b; logic [31:0] r;
    b = log_n;
    xfer(1'b0, 28'hE000003, 32'd0, r);
    check("R6 ident data", r, 32'h0000008F);
    chk_log("R6 ident cmd", b, 0, 16'h0090, 24'h0);
    b = log_n;
    xfer(1'b0, 28'hE010010, 32'd0, r);
    check("R6 query data", r, 32'h00000071);
    chk_log("R6 query cmd", b, 0, 16'h0098, 24'h0);
  endtask

  task automatic t_control;
    int b; logic [31:0] r;
    b = log_n;
    xfer(1'b1, 28'hC000000, 32'h2, r);
    check("R8 clear log length", log_n - b, 1);
    chk_log("R8 clear cmd", b, 0, 16'h0050, 24'h0);
    xfer(1'b0, 28'hC000004, 32'd0, r);
    check("R8 status cleared", r, 32'd0);
    b = log_n;
    xfer(1'b1, 28'hC000000, 32'h4, r);
    check("R8 reset log length", log_n - b, 1);
    chk_log("R8 reset cmd", b, 0, 16'h00FF, 24'h0);
    b = log_n;
    xfer(1'b1, 28'hC000000, 32'h6, r);
    check("R8 both log length", log_n - b, 2);
    chk_log("R8 both first", b, 0, 16'h0050, 24'h0);
    chk_log("R8 both second", b, 1, 16'h00FF, 24'h0);
    b = log_n;
    xfer(1'b1, 28'hC000000, 32'h0, r);
    check("R8 no bits no cycle", log_n - b, 0);
  endtask

  task automatic t_unused;
    int b; logic [31:0] r;
    b = log_n;
    xfer(1'b0, 28'h4000020, 32'd0, r);
    check("R1 unlock-window read data", r, 32'd0);
    xfer(1'b1, 28'hE000000, 32'h90, r);
    check("R1 unused accesses no cycle", log_n - b, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_program();
    t_array_read();
    t_unlock();
    t_erase();
    t_status_ignore();
    t_ident_query();
    t_control();
    t_unused();
    repeat (4) @(posedge clk);
    check("R10 cycle widths", bad_len, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule